// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves 8-bit characters over a three-wire synchronous serial link: one clock line, one data line out and one data line in. The transmit path and the receive path work independently but are paced by one shared serial clock, so a single character slot can carry a byte out and a byte in at the same time. Characters carry no framing, parity or address bits. The least significant bit goes first.

The serial clock comes from one of two sources. The first is an internal divider, whose output is driven onto the clock pin. The second is an external clock that the block synchronizes and edge-detects. Both directions are double-buffered. Software can queue the next transmit byte while the current one is shifting. It can also leave the last received byte in place while the next one arrives. As a result, characters can follow one another with no idle clock period between them.

With the internal clock and receive enabled, the block keeps clocking characters in. It stops only when a character is lost to an overrun, or when receive is disabled; in both cases it first finishes the character in progress.

Top module: `syncSerialXcvr`

## Requirements
- R1: A transmitted character is exactly 8 bits on `sdOut`, bit 0 first and bit 7 last, one bit per serial clock period.
- R2: The receiver shifts in 8 bits from `sdIn`, the first one into bit 0. After the 8th bit it presents the byte on `rxData` and raises `rxFull`. `rxRead` clears `rxFull`.
- R3: `sdOut` changes only on a falling serial clock edge, and `sdIn` is sampled on the rising serial clock edge.
- R4: After bit 7 has been sent, `sdOut` keeps the value of bit 7 until the next transmitted character begins.
- R5: With the internal clock (`useExt`=0), `sckOe` is 1 and `sckOut` makes exactly 8 low pulses per character. When no character is in progress, `sckOut` stays high.
- R6: The internal serial clock period is 2×(`baudDiv`+1) system clocks. This period also holds across the boundary between back-to-back characters.
- R7: With the internal clock and receive enabled, characters keep being clocked until an overrun occurs or `rxEn` is cleared. The clock stops high after the character in progress completes.
- R8: If a character completes while `rxFull` is 1 and `rxRead` is not asserted, `overrun` is set and that character is discarded, leaving `rxData` unchanged. `overrun` stays set until `ovrClear` is asserted.
- R9: `txEmpty` rises on the falling clock edge that moves the holding byte into the shifter. If a byte is waiting when a character ends, the next character starts one half-period later, with no idle gap.
- R10: With `useExt`=1, `sckOe` is 0. Transmit and receive follow the edges of `sckIn`, which must run at no more than a quarter of the system clock frequency.
- R11: After reset, `txEmpty`=1, `rxFull`=0, `overrun`=0 and `sckOut`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| useExt | input | 1 | 1 selects the external serial clock `sckIn` |
| baudDiv | input | 8 | Internal divider value N; the period is 2×(N+1) clocks |
| txEn | input | 1 | Transmit enable |
| rxEn | input | 1 | Receive enable |
| txWrite | input | 1 | Write strobe for the transmit holding byte |
| txData | input | 8 | Byte to transmit |
| txEmpty | output | 1 | Transmit holding register free |
| rxRead | input | 1 | Acknowledges the received byte and clears `rxFull` |
| rxData | output | 8 | Last received byte |
| rxFull | output | 1 | Received byte waiting |
| overrun | output | 1 | Sticky flag: a received character was lost |
| ovrClear | input | 1 | Clears `overrun` |
| sckIn | input | 1 | External serial clock |
| sckOut | output | 1 | Internal serial clock, idle high |
| sckOe | output | 1 | Output enable for `sckOut` |
| sdIn | input | 1 | Serial data in |
| sdOut | output | 1 | Serial data out |

## Verification
A corrupted bit counter shows up within one character. The pulse count on `sckOut` or the bit order of a captured byte would be off, and `rxFull` would rise on the wrong edge. A divider or start condition that is wrong shows up at the first falling edge, as a fall-to-fall interval other than 2×(N+1), including across a back-to-back boundary. A flag state error, such as a lost overrun or an overwritten held byte, becomes visible on the ports at the completion of the next character.

// File: rtl/sscPkg.sv
package sscPkg;
  localparam int CHAR_BITS = 8;
  localparam int IDX_W     = $clog2(CHAR_BITS);

  typedef struct packed {
    logic             startChar;  // falling edge opens a character
    logic             startTx;    // holding byte moves to shifter
    logic             startRx;    // receiver takes part in this character
    logic             shiftTx;    // falling edge inside a character
    logic             sampleRx;   // rising edge inside a character
    logic             lastBit;    // this rising edge ends the character
    logic [IDX_W-1:0] bitIdx;     // rising edges seen so far
  } sscStrobe_t;
endpackage

// File: rtl/sscCtrl.sv
module sscCtrl
  import sscPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             useExt,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             sckIn,
  input  logic             txEn,
  input  logic             rxEn,
  input  logic             txFull,
  input  logic             overrun,
  output logic             sckOut,
  output logic             sckOe,
  output sscStrobe_t       stb
);
  localparam int SYNC_N = 3;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAR_BITS - 1);

  logic [SYNC_N-1:0] syncQ;
  logic [DIV_W-1:0]  divCnt;
  logic              sckReg;
  logic              inChar;
  logic [IDX_W-1:0]  bitCnt;
  logic              go, run, tickInt, fallEv, riseEv, extFall, extRise;

  // two synchronizer flops plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_N-2:0], sckIn};

  assign extFall = syncQ[2] & ~syncQ[1];
  assign extRise = ~syncQ[2] & syncQ[1];

  assign go      = (txEn && txFull) || (rxEn && !overrun);
  assign run     = !sckReg || inChar || go;
  assign tickInt = !useExt && run && (divCnt == baudDiv);
  assign fallEv  = useExt ? extFall : (tickInt && sckReg);
  assign riseEv  = useExt ? extRise : (tickInt && !sckReg);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      divCnt <= '0;
      sckReg <= 1'b1;
    end else if (useExt || !run) begin
      divCnt <= '0;
      sckReg <= 1'b1;
    end else if (divCnt == baudDiv) begin
      divCnt <= '0;
      sckReg <= ~sckReg;
    end else begin
      divCnt <= divCnt + 1'b1;
    end

  always_comb begin
    stb.startChar = fallEv && !inChar && go;
    stb.startTx   = stb.startChar && txEn && txFull;
    stb.startRx   = stb.startChar && rxEn && !overrun;
    stb.shiftTx   = fallEv && inChar;
    stb.sampleRx  = riseEv && inChar;
    stb.lastBit   = stb.sampleRx && (bitCnt == LAST_IDX);
    stb.bitIdx    = bitCnt;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      inChar <= 1'b0;
      bitCnt <= '0;
    end else if (stb.startChar) begin
      inChar <= 1'b1;
      bitCnt <= '0;
    end else if (stb.sampleRx) begin
      inChar <= !stb.lastBit;
      bitCnt <= stb.lastBit ? '0 : bitCnt + 1'b1;
    end

  assign sckOut = sckReg;
  assign sckOe  = !useExt;
endmodule

// File: rtl/sscData.sv
module sscData
  import sscPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  sscStrobe_t           stb,
  input  logic                 txWrite,
  input  logic [CHAR_BITS-1:0] txData,
  input  logic                 rxRead,
  input  logic                 ovrClear,
  input  logic                 sdIn,
  output logic                 sdOut,
  output logic                 txFull,
  output logic [CHAR_BITS-1:0] rxData,
  output logic                 rxFull,
  output logic                 overrun
);
  logic [CHAR_BITS-1:0] txHold, txShift, rxShift, rxNext;
  logic                 txAct, rxAct, lose;

  assign rxNext = {sdIn, rxShift[CHAR_BITS-1:1]};
  assign lose   = stb.lastBit && rxAct && rxFull && !rxRead;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      txHold <= '0;
      txFull <= 1'b0;
    end else if (txWrite) begin
      txHold <= txData;
      txFull <= 1'b1;
    end else if (stb.startTx) begin
      txFull <= 1'b0;
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      txShift <= '0;
      txAct   <= 1'b0;
      rxAct   <= 1'b0;
      sdOut   <= 1'b1;
    end else if (stb.startChar) begin
      txAct <= stb.startTx;
      rxAct <= stb.startRx;
      if (stb.startTx) begin
        txShift <= txHold;
        sdOut   <= txHold[0];
      end
    end else if (stb.shiftTx && txAct) begin
      sdOut <= txShift[stb.bitIdx];
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      rxFull  <= 1'b0;
    end else begin
      if (stb.sampleRx) rxShift <= rxNext;
      if (stb.lastBit && rxAct && !lose) begin
        rxData <= rxNext;
        rxFull <= 1'b1;
      end else if (rxRead) begin
        rxFull <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)         overrun <= 1'b0;
    else if (lose)     overrun <= 1'b1;
    else if (ovrClear) overrun <= 1'b0;
endmodule

// File: rtl/syncSerialXcvr.sv
module syncSerialXcvr
  import sscPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             useExt,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             txEn,
  input  logic             rxEn,
  input  logic             txWrite,
  input  logic [7:0]       txData,
  output logic             txEmpty,
  input  logic             rxRead,
  output logic [7:0]       rxData,
  output logic             rxFull,
  output logic             overrun,
  input  logic             ovrClear,
  input  logic             sckIn,
  output logic             sckOut,
  output logic             sckOe,
  input  logic             sdIn,
  output logic             sdOut
);
  sscStrobe_t stb;
  logic       txFull;

  sscCtrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .useExt(useExt), .baudDiv(baudDiv),
    .sckIn(sckIn), .txEn(txEn), .rxEn(rxEn), .txFull(txFull),
    .overrun(overrun), .sckOut(sckOut), .sckOe(sckOe), .stb(stb)
  );

  sscData uData (
    .clk(clk), .rstN(rstN), .stb(stb), .txWrite(txWrite), .txData(txData),
    .rxRead(rxRead), .ovrClear(ovrClear), .sdIn(sdIn), .sdOut(sdOut),
    .txFull(txFull), .rxData(rxData), .rxFull(rxFull), .overrun(overrun)
  );

  assign txEmpty = !txFull;
endmodule

// File: rtl/sscChecker.sv
module sscChecker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             useExt,
  input logic             txEn,
  input logic             ovrClear,
  input logic             txEmpty,
  input logic [7:0]       rxData,
  input logic             rxFull,
  input logic             overrun,
  input logic             sckOut,
  input logic             sdOut
);
  // R8: flag is sticky until cleared
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !ovrClear |=> overrun);

  // R8: the lost character leaves the held byte alone
  a_r8_discard: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $stable(rxData));

  // R3: data out moves only with a falling internal clock edge
  a_r3_tx_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !useExt && !$stable(sdOut) |-> $fell(sckOut));

  // R2: a received byte appears on a rising internal clock edge
  a_r2_rx_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    !useExt && $rose(rxFull) |-> $rose(sckOut));

  // R9: the holding register empties on a falling edge
  a_r9_empty_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !useExt && $rose(txEmpty) |-> $fell(sckOut));

  // R7: after an overrun with transmit off, the clock stays parked high
  a_r7_parked: assert property (@(posedge clk) disable iff (!rstN)
    !useExt && $past(!useExt) && !txEn && overrun && sckOut |=> sckOut);
endmodule

bind syncSerialXcvr sscChecker #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_syncSerialXcvr.sv
`timescale 1ns/1ps
module sim_syncSerialXcvr;
  logic clk = 0, rstN = 0, useExt = 0, txEn = 0, rxEn = 0, txWrite = 0;
  logic rxRead = 0, ovrClear = 0, sckIn = 1, sdIn = 0;
  logic [7:0] baudDiv = 0, txData = 0, rxData;
  logic txEmpty, rxFull, overrun, sckOut, sckOe, sdOut;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  syncSerialXcvr u0 (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // serial peer model driven from the observed clock line
  logic [7:0] periByte [4];
  logic [7:0] capByte [4];
  int  riseCnt = 0, lastFall = 0, badPer = 0, expPer = 2;
  bit  haveFall = 0, prevSck = 1;

  always @(negedge clk) begin
    if (rstN && !useExt) begin
      if (prevSck && !sckOut) begin
        if (haveFall && (cyc - lastFall) != expPer) badPer++;
        haveFall = 1;
        lastFall = cyc;
        sdIn = periByte[(riseCnt/8)%4][riseCnt%8];
      end
      if (!prevSck && sckOut) begin
        capByte[(riseCnt/8)%4][riseCnt%8] = sdOut;
        riseCnt++;
      end
    end
    prevSck = sckOut;
  end

  function automatic int periodOf(input logic [7:0] n);
    return 2 * (int'(n) + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic monReset(input logic [7:0] n);
    riseCnt = 0; haveFall = 0; badPer = 0; expPer = periodOf(n);
    for (int i = 0; i < 4; i++) begin
      capByte[i] = 0;
      periByte[i] = 8'($urandom);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeTx(input logic [7:0] d);
    txData = d; txWrite = 1; tick(1); txWrite = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; tick(1); s = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    tick(3); rstN = 1; tick(1);
    // R11 reset state
    chk(txEmpty == 1, "R11 txEmpty", txEmpty, 1);
    chk(rxFull == 0, "R11 rxFull", rxFull, 0);
    chk(overrun == 0, "R11 overrun", overrun, 0);
    chk(sckOut == 1, "R11 sckOut", sckOut, 1);
    chk(sckOe == 1, "R5 sckOe internal", sckOe, 1);

    // transmit only, back to back characters
    for (int it = 0; it < 3; it++) begin
      logic [7:0] t0, t1;
      baudDiv = (it == 0) ? 8'd0 : 8'($urandom_range(1, 4));
      t0 = (it == 1) ? 8'h80 : 8'($urandom);
      t1 = (it == 1) ? 8'h01 : 8'($urandom);
      monReset(baudDiv);
      txEn = 1;
      writeTx(t0);
      while (!txEmpty) tick(1);
      chk(riseCnt == 0, "R9 empty at first fall", riseCnt, 0);
      writeTx(t1);
      while (riseCnt < 16) tick(1);
      tick(4 * periodOf(baudDiv) + 4);
      chk(capByte[0] == t0, "R1 first byte", capByte[0], t0);
      chk(capByte[1] == t1, "R1 second byte", capByte[1], t1);
      chk(riseCnt == 16, "R5 pulse count", riseCnt, 16);
      chk(badPer == 0, "R6 R9 period no gap", badPer, 0);
      chk(sdOut == t1[7], "R4 msb held", sdOut, t1[7]);
      chk(sckOut == 1, "R5 idle high", sckOut, 1);
      chk(txEmpty == 1, "R9 empty after", txEmpty, 1);
      txEn = 0;
    end

    // receive only: runs until overrun
    baudDiv = 8'($urandom_range(0, 3));
    monReset(baudDiv);
    rxEn = 1;
    while (!overrun) tick(1);
    tick(6 * periodOf(baudDiv));
    chk(riseCnt == 16, "R7 stops at overrun", riseCnt, 16);
    chk(rxData == periByte[0], "R2 R8 held byte kept", rxData, periByte[0]);
    chk(badPer == 0, "R6 rx period", badPer, 0);
    chk(overrun == 1, "R8 overrun sticky", overrun, 1);
    rxEn = 0;
    pulse(ovrClear);
    pulse(rxRead);
    tick(6 * periodOf(baudDiv));
    chk(overrun == 0, "R8 cleared", overrun, 0);
    chk(rxFull == 0, "R2 read clears", rxFull, 0);
    chk(riseCnt == 16, "R7 rxEn off no clock", riseCnt, 16);

    // full duplex, receive disabled after one character
    baudDiv = 8'($urandom_range(0, 5));
    monReset(baudDiv);
    begin
      logic [7:0] t0;
      t0 = 8'($urandom);
      txEn = 1;
      writeTx(t0);
      rxEn = 1;
      while (!rxFull) tick(1);
      rxEn = 0;
      tick(6 * periodOf(baudDiv));
      chk(capByte[0] == t0, "R1 duplex tx", capByte[0], t0);
      chk(rxData == periByte[0], "R2 duplex rx", rxData, periByte[0]);
      chk(riseCnt == 8, "R7 stop on rxEn clear", riseCnt, 8);
      pulse(rxRead);
      txEn = 0;
    end

    // external serial clock
    begin
      logic [7:0] t0, p0, cap;
      t0 = 8'($urandom); p0 = 8'($urandom); cap = 0;
      useExt = 1; txEn = 1; rxEn = 1;
      tick(2);
      chk(sckOe == 0, "R10 sckOe external", sckOe, 0);
      writeTx(t0);
      for (int b = 0; b < 8; b++) begin
        sckIn = 0; sdIn = p0[b];
        tick(6);
        cap[b] = sdOut;
        sckIn = 1;
        tick(6);
      end
      tick(6);
      chk(cap == t0, "R10 external tx", cap, t0);
      chk(rxFull == 1, "R10 external rxFull", rxFull, 1);
      chk(rxData == p0, "R10 external rx", rxData, p0);
      rxEn = 0; txEn = 0;
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule